// File: doc/BRIEF.md
# Pipeline Exception Status Controller

This block carries a small status code for every instruction through a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It also produces the control signals that keep a faulting instruction, and everything behind it, from changing architectural state. The fetch stage gives each instruction its code from the instruction-memory error flag, the instruction-valid flag and the fetched opcode. The decode and execute stages pass the code along unchanged. The memory stage can turn it into a bad-address code when the data memory reports an error. The code becomes visible as the processor status only when the instruction reaches writeback.

The side-effect controls are decided combinationally, in the same cycle in which the memory stage sees the fault. These controls are the condition-code update enable, the data-memory write enable, the memory-stage bubble and the writeback stall. Once a fault reaches writeback, the writeback register freezes and the memory stage keeps taking bubbles. The pipeline therefore stops with the faulting code on display; no handler is called. An illegal instruction travels as a bubble that still carries its illegal code, so it never writes a register.

The status registers hold their own state. The block has no data stream, so every pin is a plain control or status signal. There is no handshake.

Top module: `pipe_stat_ctrl`

## Requirements
- R1: Status codes are 3 bits wide: BUB=0, AOK=1, HLT=2, ADR=3, INS=4. While rst_n is low, every stage register loads BUB. After reset, d_stat, e_stat, m_in_stat and w_stat all read 0, and proc_stat reads AOK (1).
- R2: On each clock edge the decode status register d_stat loads the fetch status. The fetch status is chosen by priority:
  - imem_err=1 gives ADR;
  - otherwise instr_valid=0 gives INS;
  - otherwise f_opcode==HALT_OP gives HLT;
  - otherwise the result is AOK.
- R3: The execute status e_stat equals the d_stat of the previous cycle; the decode and execute stages never alter the code.
- R4: m_stat is ADR whenever dmem_err=1, and otherwise equals m_in_stat.
- R5: m_bubble is 1 exactly when m_stat or w_stat is one of HLT, ADR or INS. On the next edge m_in_stat loads BUB when m_bubble=1, and otherwise loads e_stat.
- R6: cc_en is 1 exactly when all three of these hold:
  - e_opcode==ALU_OP;
  - m_stat is not HLT, ADR or INS;
  - w_stat is not HLT, ADR or INS.
- R7: dmem_wr_en is 1 exactly when neither m_stat nor w_stat is HLT, ADR or INS.
- R8: w_stall is 1 exactly when w_stat is HLT, ADR or INS. When w_stall=1, w_stat keeps its value on the next edge. When w_stall=0, w_stat loads m_stat.
- R9: proc_stat is AOK when w_stat is BUB, and otherwise equals w_stat.
- R10: wb_wr_en is 1 only when w_stat is AOK. A bubble, or an illegal instruction travelling as INS, performs no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_err | input | 1 | Instruction fetch address fault |
| instr_valid | input | 1 | Fetched opcode is a legal instruction |
| f_opcode | input | OPW | Opcode of the fetched instruction |
| dmem_err | input | 1 | Data-memory address fault in the memory stage |
| e_opcode | input | OPW | Opcode of the instruction in execute |
| d_stat | output | 3 | Decode-stage status register |
| e_stat | output | 3 | Execute-stage status register |
| m_in_stat | output | 3 | Memory-stage status register (incoming) |
| m_stat | output | 3 | Memory-stage status after the data-memory check |
| w_stat | output | 3 | Writeback-stage status register |
| cc_en | output | 1 | Condition-code update enable |
| dmem_wr_en | output | 1 | Data-memory write permitted |
| m_bubble | output | 1 | Load a bubble into the memory stage next edge |
| w_stall | output | 1 | Hold the writeback register |
| wb_wr_en | output | 1 | Register-file write permitted in writeback |
| proc_stat | output | 3 | Processor status |

## Verification
The bench builds the block with OPW=4, HALT_OP=0, ALU_OP=6 and two pass-through middle stages. With a 4-bit opcode, all 64 combinations of fetch error, valid flag and opcode can be swept, each one followed through to writeback after a fresh reset. Sparse pseudo-random faults in fetch and memory, together with random execute opcodes, then produce overlapping cases. In these, a memory-stage fault meets an earlier writeback fault, or meets an ALU operation in execute. Every output is compared in every cycle against a status model computed from the requirements.

// File: rtl/pipe_stat_pkg.sv
package pipe_stat_pkg;
  localparam int STW = 3;

  typedef enum logic [STW-1:0] {
    ST_BUB = 3'd0,
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } stat_e;

  function automatic logic is_fault(stat_e s);
    return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
  endfunction
endpackage

// File: rtl/fetch_stat_sel.sv
module fetch_stat_sel
  import pipe_stat_pkg::*;
#(
  parameter int OPW     = 4,
  parameter int HALT_OP = 0
) (
  input  logic           imem_err,
  input  logic           instr_valid,
  input  logic [OPW-1:0] f_opcode,
  output stat_e          f_stat
);
  localparam logic [OPW-1:0] HALT_CODE = OPW'(HALT_OP);

  always_comb begin
    if (imem_err)                    f_stat = ST_ADR;
    else if (!instr_valid)           f_stat = ST_INS;
    else if (f_opcode == HALT_CODE)  f_stat = ST_HLT;
    else                             f_stat = ST_AOK;
  end
endmodule

// File: rtl/stat_stage.sv
module stat_stage
  import pipe_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_e d,
  input  logic  bubble,
  input  logic  stall,
  output stat_e q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= ST_BUB;
    else if (stall)  q <= q;
    else if (bubble) q <= ST_BUB;
    else             q <= d;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import pipe_stat_pkg::*;
#(
  parameter int OPW    = 4,
  parameter int ALU_OP = 6
) (
  input  stat_e          m_stat,
  input  stat_e          w_stat,
  input  logic [OPW-1:0] e_opcode,
  output logic           cc_en,
  output logic           dmem_wr_en,
  output logic           m_bubble,
  output logic           w_stall,
  output logic           wb_wr_en,
  output stat_e          proc_stat
);
  localparam logic [OPW-1:0] ALU_CODE = OPW'(ALU_OP);

  logic m_fault, w_fault, quiet;

  always_comb begin
    m_fault    = is_fault(m_stat);
    w_fault    = is_fault(w_stat);
    quiet      = !m_fault && !w_fault;
    cc_en      = quiet && (e_opcode == ALU_CODE);
    dmem_wr_en = quiet;
    m_bubble   = m_fault || w_fault;
    w_stall    = w_fault;
    wb_wr_en   = (w_stat == ST_AOK);
    proc_stat  = (w_stat == ST_BUB) ? ST_AOK : w_stat;
  end
endmodule

// File: rtl/pipe_stat_ctrl.sv
module pipe_stat_ctrl
  import pipe_stat_pkg::*;
#(
  parameter int OPW        = 4,
  parameter int HALT_OP    = 0,
  parameter int ALU_OP     = 6,
  parameter int MID_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           imem_err,
  input  logic           instr_valid,
  input  logic [OPW-1:0] f_opcode,
  input  logic           dmem_err,
  input  logic [OPW-1:0] e_opcode,
  output logic [2:0]     d_stat,
  output logic [2:0]     e_stat,
  output logic [2:0]     m_in_stat,
  output logic [2:0]     m_stat,
  output logic [2:0]     w_stat,
  output logic           cc_en,
  output logic           dmem_wr_en,
  output logic           m_bubble,
  output logic           w_stall,
  output logic           wb_wr_en,
  output logic [2:0]     proc_stat
);
  localparam int LAST = (MID_STAGES < 2) ? 2 : MID_STAGES;

  stat_e chain [0:LAST];
  stat_e m_q, m_chk, w_q, ps;

  fetch_stat_sel #(.OPW(OPW), .HALT_OP(HALT_OP)) u_fetch (
    .imem_err(imem_err), .instr_valid(instr_valid),
    .f_opcode(f_opcode), .f_stat(chain[0])
  );

  for (genvar i = 0; i < LAST; i++) begin : g_mid
    stat_stage u_stg (
      .clk(clk), .rst_n(rst_n), .d(chain[i]),
      .bubble(1'b0), .stall(1'b0), .q(chain[i+1])
    );
  end

  stat_stage u_mem (
    .clk(clk), .rst_n(rst_n), .d(chain[LAST]),
    .bubble(m_bubble), .stall(1'b0), .q(m_q)
  );

  assign m_chk = dmem_err ? ST_ADR : m_q;

  stat_stage u_wb (
    .clk(clk), .rst_n(rst_n), .d(m_chk),
    .bubble(1'b0), .stall(w_stall), .q(w_q)
  );

  exc_ctrl #(.OPW(OPW), .ALU_OP(ALU_OP)) u_ctrl (
    .m_stat(m_chk), .w_stat(w_q), .e_opcode(e_opcode),
    .cc_en(cc_en), .dmem_wr_en(dmem_wr_en), .m_bubble(m_bubble),
    .w_stall(w_stall), .wb_wr_en(wb_wr_en), .proc_stat(ps)
  );

  assign d_stat    = chain[1];
  assign e_stat    = chain[LAST];
  assign m_in_stat = m_q;
  assign m_stat    = m_chk;
  assign w_stat    = w_q;
  assign proc_stat = ps;
endmodule

// File: rtl/pipe_stat_chk.sv
module pipe_stat_chk #(
  parameter int OPW    = 4,
  parameter int ALU_OP = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dmem_err,
  input logic [OPW-1:0] e_opcode,
  input logic [2:0]     d_stat,
  input logic [2:0]     e_stat,
  input logic [2:0]     m_in_stat,
  input logic [2:0]     m_stat,
  input logic [2:0]     w_stat,
  input logic           cc_en,
  input logic           dmem_wr_en,
  input logic           m_bubble,
  input logic           w_stall,
  input logic           wb_wr_en,
  input logic [2:0]     proc_stat
);
  function automatic logic flt(logic [2:0] s);
    return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
  endfunction

  // R3: execute follows decode one cycle later
  p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    e_stat == $past(d_stat));

  // R4: a data-memory error forces the bad-address code
  p_mem_adr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_err |-> m_stat == 3'd3);

  // R5: a bubble request empties the memory stage on the next edge
  p_mem_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_bubble |=> m_in_stat == 3'd0);

  // R6: no condition-code update around a fault
  p_cc_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt(m_stat) || flt(w_stat)) |-> !cc_en);

  // R6: updates only for the ALU opcode
  p_cc_alu_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cc_en |-> e_opcode == OPW'(ALU_OP));

  // R7: no data-memory write around a fault
  p_wr_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt(m_stat) || flt(w_stat)) |-> !dmem_wr_en);

  // R8: a stalled writeback register holds
  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w_stall |=> $stable(w_stat));

  // R9: bubble in writeback reports AOK
  p_proc_bub_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat == 3'd0) |-> proc_stat == 3'd1);

  // R10: register writes only for AOK instructions
  p_wb_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_wr_en |-> w_stat == 3'd1);
endmodule

bind pipe_stat_ctrl pipe_stat_chk #(.OPW(OPW), .ALU_OP(ALU_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .dmem_err(dmem_err), .e_opcode(e_opcode),
  .d_stat(d_stat), .e_stat(e_stat), .m_in_stat(m_in_stat),
  .m_stat(m_stat), .w_stat(w_stat), .cc_en(cc_en),
  .dmem_wr_en(dmem_wr_en), .m_bubble(m_bubble), .w_stall(w_stall),
  .wb_wr_en(wb_wr_en), .proc_stat(proc_stat)
);

// File: tb/tb_pipe_stat_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_stat_ctrl;
  localparam int OPW = 4, HALT_OP = 0, ALU_OP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imem_err = 1'b0, instr_valid = 1'b1, dmem_err = 1'b0;
  logic [OPW-1:0] f_opcode = 4'd1, e_opcode = 4'd0;
  logic [2:0] d_stat, e_stat, m_in_stat, m_stat, w_stat, proc_stat;
  logic cc_en, dmem_wr_en, m_bubble, w_stall, wb_wr_en;

  int tests = 0, fails = 0;
  int md, me, mm, mw;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  pipe_stat_ctrl #(.OPW(OPW), .HALT_OP(HALT_OP), .ALU_OP(ALU_OP)) dut (
    .clk(clk), .rst_n(rst_n), .imem_err(imem_err), .instr_valid(instr_valid),
    .f_opcode(f_opcode), .dmem_err(dmem_err), .e_opcode(e_opcode),
    .d_stat(d_stat), .e_stat(e_stat), .m_in_stat(m_in_stat), .m_stat(m_stat),
    .w_stat(w_stat), .cc_en(cc_en), .dmem_wr_en(dmem_wr_en),
    .m_bubble(m_bubble), .w_stall(w_stall), .wb_wr_en(wb_wr_en),
    .proc_stat(proc_stat)
  );

  function automatic bit flt(int s);
    return (s == 2) || (s == 3) || (s == 4);
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; imem_err = 1'b0; instr_valid = 1'b1;
    f_opcode = 4'd1; dmem_err = 1'b0; e_opcode = 4'd0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 d_stat", d_stat, 0);
    chk("R1 e_stat", e_stat, 0);
    chk("R1 m_in_stat", m_in_stat, 0);
    chk("R1 w_stat", w_stat, 0);
    chk("R1 proc_stat", proc_stat, 1);
    rst_n = 1'b1;
    md = 0; me = 0; mm = 0; mw = 0;
  endtask

  // inputs are already applied, in the low phase
  task automatic step();
    int fs, ms;
    bit mb, ws;
    #2;
    fs = imem_err ? 3 : (!instr_valid ? 4 : ((f_opcode == OPW'(HALT_OP)) ? 2 : 1));
    ms = dmem_err ? 3 : mm;
    mb = flt(ms) || flt(mw);
    ws = flt(mw);
    chk("R2 d_stat", d_stat, md);
    chk("R3 e_stat", e_stat, me);
    chk("R5 m_in_stat", m_in_stat, mm);
    chk("R4 m_stat", m_stat, ms);
    chk("R8 w_stat", w_stat, mw);
    chk("R5 m_bubble", m_bubble, mb);
    chk("R8 w_stall", w_stall, ws);
    chk("R6 cc_en", cc_en, (e_opcode == OPW'(ALU_OP)) && !flt(ms) && !flt(mw));
    chk("R7 dmem_wr_en", dmem_wr_en, !flt(ms) && !flt(mw));
    chk("R10 wb_wr_en", wb_wr_en, mw == 1);
    chk("R9 proc_stat", proc_stat, (mw == 0) ? 1 : mw);
    mw = ws ? mw : ms;
    mm = mb ? 0 : me;
    me = md;
    md = fs;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // exhaustive fetch sweep, each followed to writeback
    for (int t = 0; t < 64; t++) begin
      do_reset();
      for (int c = 0; c < 9; c++) begin
        if (c == 0) begin
          imem_err = t[5]; instr_valid = t[4]; f_opcode = t[3:0];
        end else begin
          imem_err = 1'b0; instr_valid = 1'b1; f_opcode = 4'd1;
        end
        dmem_err = 1'b0;
        e_opcode = OPW'(c % 8);
        step();
      end
    end
    // sparse random faults
    for (int t = 0; t < 400; t++) begin
      do_reset();
      for (int c = 0; c < 12; c++) begin
        lfsr = nxt(lfsr);
        imem_err    = (lfsr[3:0] == 4'd0);
        instr_valid = (lfsr[7:4] != 4'd0);
        f_opcode    = lfsr[11:8];
        lfsr = nxt(lfsr);
        dmem_err    = (lfsr[3:0] == 4'd5);
        e_opcode    = lfsr[7:4] ^ lfsr[11:8];
        step();
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule